// File: doc/BRIEF.md
# Debug Observability Pin Multiplexer

This block holds a 32-bit control register that lets debug software route one internal DMA-request line and one internal interrupt line onto the two serial-port pins of the chip: the receive-line pin and the transmit-line pin. Each pin has its own selector field. A selector of zero leaves the pin on its normal functional path from the serial port, including that path's own direction control. A nonzero selector in the legal range drives the chosen internal line onto the pin and forces the pin to output.

The selector ranges are split into contiguous blocks, one per source group. The DMA selector covers the DSP DMA requests and then the system DMA requests. The interrupt selector covers DSP level-2, DSP level-1, MPU level-1 and MPU level-2 interrupts, in that order. The block takes no effect until a key value has been written to a separate compatibility register. While that key is absent, writes to the multiplexing register are dropped and both pins stay on their functional paths.

Top module: `dbg_obs_pinmux`

## Requirements
- R1: After reset, the multiplexing register at byte offset 0x10 reads 0 and the compatibility register at offset 0x00 reads 0. Both pins carry their functional value and direction.
- R2: Writing 0x0000EAEF to offset 0x00 unlocks the block, and offset 0x00 then reads 0x0000EAEF. Writing any other value to offset 0x00 locks it again, and offset 0x00 then reads 0.
- R3: While the block is locked, a write to offset 0x10 leaves the read-back value unchanged, and both pins carry their functional value and direction.
- R4: At offset 0x10, bits 18:13 hold the DMA selector and bits 12:6 hold the interrupt selector. Bits 31:19 and 5:0 read as 0 whatever was written. Any offset other than 0x00 and 0x10 reads 0.
- R5: DMA selector values 1 to 19 put DSP DMA request bit s (no offset) onto the receive-line pin.
- R6: DMA selector values 20 to 50 put system DMA request bit s-20 onto the receive-line pin.
- R7: Interrupt selector values 1 to 16 put DSP level-2 interrupt s-1 onto the transmit-line pin. Values 17 to 37 put DSP level-1 interrupt s-17 onto that pin.
- R8: Interrupt selector values 38 to 69 put MPU level-1 interrupt s-38 onto the transmit-line pin. Values 70 to 101 put MPU level-2 interrupt s-70 onto that pin.
- R9: A DMA selector above 50 or an interrupt selector above 101 leaves its pin in functional mode.
- R10: A pin that shows a selected line has its output enable at 1. A pin in functional mode passes through the functional output and the functional output enable unchanged.
- R11: Locking the block again sends both pins back to functional mode and keeps the stored selectors. Unlocking it once more restores the observed lines without a new write to offset 0x10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| dsp_dma_req | input | 20 | DSP DMA requests; bit 0 is not used |
| sys_dma_req | input | 31 | System DMA requests |
| dsp_l2_irq | input | 16 | DSP level-2 interrupts |
| dsp_l1_irq | input | 21 | DSP level-1 interrupts |
| mpu_l1_irq | input | 32 | MPU level-1 interrupts |
| mpu_l2_irq | input | 32 | MPU level-2 interrupts |
| rx_func_out | input | 1 | Functional value for the receive-line pin |
| rx_func_oe | input | 1 | Functional direction for the receive-line pin |
| tx_func_out | input | 1 | Functional value for the transmit-line pin |
| tx_func_oe | input | 1 | Functional direction for the transmit-line pin |
| rx_pin_out | output | 1 | Value to the receive-line pad |
| rx_pin_oe | output | 1 | Output enable to the receive-line pad |
| tx_pin_out | output | 1 | Value to the transmit-line pad |
| tx_pin_oe | output | 1 | Output enable to the transmit-line pad |

## Verification
The assertions assume that reg_wr is a clean one-cycle strobe, that reg_addr is stable while it is high, and that the source vectors may change freely between clock edges, because the pin path is purely combinational. The stimulus drives every input on the falling edge and holds each write strobe for exactly one cycle. It chooses random selectors, with a bias toward the legal ranges and a share of illegal values. The directed cases land on each range edge (0, 1, 19, 20, 50, 51 and 1, 16, 17, 37, 38, 69, 70, 101, 102). At each of those edges, a one-hot source pattern and its inverse show which single line was picked.

// File: rtl/obs_pinmux_pkg.sv
package obs_pinmux_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned DSEL_W   = 6;
   localparam int unsigned DSEL_LSB = 13;
   localparam int unsigned ISEL_W   = 7;
   localparam int unsigned ISEL_LSB = 6;
   localparam logic [REG_W-1:0] UNLOCK_KEY = 32'h0000_EAEF;

   typedef struct packed {
      logic [DSEL_W-1:0] dsel;
      logic [ISEL_W-1:0] isel;
   } sel_pair_t;
endpackage

// File: rtl/obs_cfg_regs.sv
module obs_cfg_regs
   import obs_pinmux_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned COMPAT_OFS = 'h00,
   parameter int unsigned MUX_OFS    = 'h10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output sel_pair_t         sel_q,
   output logic              unlocked
);
   localparam logic [ADDR_W-1:0] A_COMPAT = ADDR_W'(COMPAT_OFS);
   localparam logic [ADDR_W-1:0] A_MUX    = ADDR_W'(MUX_OFS);
   localparam int unsigned TOP_RSV = REG_W - DSEL_LSB - DSEL_W;

   if (ISEL_LSB + ISEL_W != DSEL_LSB) begin : g_bad_layout
      $error("selector fields must be adjacent");
   end
   if (COMPAT_OFS == MUX_OFS) begin : g_bad_ofs
      $error("register offsets must differ");
   end

   logic wr_compat, wr_mux;
   logic unused_rsv;

   assign wr_compat  = wr_en && (addr == A_COMPAT);
   assign wr_mux     = wr_en && (addr == A_MUX) && unlocked;
   assign unused_rsv = ^{wdata[REG_W-1:DSEL_LSB+DSEL_W], wdata[ISEL_LSB-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unlocked <= 1'b0;
         sel_q    <= '0;
      end else begin
         if (wr_compat) unlocked <= (wdata == UNLOCK_KEY);
         if (wr_mux) begin
            sel_q.dsel <= wdata[DSEL_LSB +: DSEL_W];
            sel_q.isel <= wdata[ISEL_LSB +: ISEL_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == A_MUX)
         rdata = {{TOP_RSV{1'b0}}, sel_q.dsel, sel_q.isel, {ISEL_LSB{1'b0}}};
      else if (addr == A_COMPAT)
         rdata = unlocked ? UNLOCK_KEY : '0;
   end

   AST_LOCKED_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_MUX && !unlocked) |=> $stable(sel_q)); // R3
   AST_KEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_COMPAT && wdata == UNLOCK_KEY) |=> unlocked); // R2
   AST_WRONG_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_COMPAT && wdata != UNLOCK_KEY) |=> !unlocked); // R2
endmodule

// File: rtl/obs_src_sel.sv
module obs_src_sel #(
   parameter int unsigned SEL_W = 6,
   parameter int unsigned N_SRC = 50
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [SEL_W-1:0] sel,
   input  logic [N_SRC-1:0] src,
   output logic             obs_bit,
   output logic             obs_act
);
   localparam int unsigned SEL_MAX = (1 << SEL_W) - 1;

   if (N_SRC > SEL_MAX) begin : g_too_many
      $error("source count exceeds selector range");
   end

   logic             in_rng;
   logic [SEL_W-1:0] idx;
   logic [N_SRC-1:0] hit;

   assign in_rng  = (sel != '0) && (int'(sel) <= N_SRC);
   assign idx     = sel - SEL_W'(1);
   assign obs_act = enable && in_rng;

   for (genvar g = 0; g < N_SRC; g++) begin : g_tap
      assign hit[g] = (int'(idx) == g) && src[g];
   end

   assign obs_bit = obs_act && (|hit);

   AST_ILLEGAL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(sel) > N_SRC) |-> !obs_act); // R9
   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == '0) |-> !obs_act); // R10
endmodule

// File: rtl/obs_pad_drv.sv
module obs_pad_drv (
   input  logic clk,
   input  logic rst_n,
   input  logic obs_act,
   input  logic obs_bit,
   input  logic func_out,
   input  logic func_oe,
   output logic pin_out,
   output logic pin_oe
);
   always_comb begin
      if (obs_act) begin
         pin_out = obs_bit;
         pin_oe  = 1'b1;
      end else begin
         pin_out = func_out;
         pin_oe  = func_oe;
      end
   end

   AST_OBS_DRIVES_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      obs_act |-> (pin_oe && pin_out == obs_bit)); // R10
endmodule

// File: rtl/dbg_obs_pinmux.sv
module dbg_obs_pinmux
   import obs_pinmux_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned COMPAT_OFS = 'h00,
   parameter int unsigned MUX_OFS    = 'h10,
   parameter int unsigned DSP_DMA_W  = 20,
   parameter int unsigned SYS_DMA_W  = 31,
   parameter int unsigned DSP_L2_W   = 16,
   parameter int unsigned DSP_L1_W   = 21,
   parameter int unsigned MPU_L1_W   = 32,
   parameter int unsigned MPU_L2_W   = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [ADDR_W-1:0]    reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [DSP_DMA_W-1:0] dsp_dma_req,
   input  logic [SYS_DMA_W-1:0] sys_dma_req,
   input  logic [DSP_L2_W-1:0]  dsp_l2_irq,
   input  logic [DSP_L1_W-1:0]  dsp_l1_irq,
   input  logic [MPU_L1_W-1:0]  mpu_l1_irq,
   input  logic [MPU_L2_W-1:0]  mpu_l2_irq,
   input  logic                 rx_func_out,
   input  logic                 rx_func_oe,
   input  logic                 tx_func_out,
   input  logic                 tx_func_oe,
   output logic                 rx_pin_out,
   output logic                 rx_pin_oe,
   output logic                 tx_pin_out,
   output logic                 tx_pin_oe
);
   localparam int unsigned N_DMA = (DSP_DMA_W - 1) + SYS_DMA_W;
   localparam int unsigned N_IRQ = DSP_L2_W + DSP_L1_W + MPU_L1_W + MPU_L2_W;

   if (DSP_DMA_W < 2) begin : g_bad_dsp
      $error("DSP DMA vector needs at least one usable bit");
   end

   sel_pair_t        sel_q;
   logic             unlocked;
   logic [N_DMA-1:0] dma_flat;
   logic [N_IRQ-1:0] irq_flat;
   logic             dma_bit, dma_act, irq_bit, irq_act;
   logic             unused_dsp0;

   // selector s maps to flat bit s-1; bit 0 of the DSP DMA vector is never reached
   assign dma_flat    = {sys_dma_req, dsp_dma_req[DSP_DMA_W-1:1]};
   assign irq_flat    = {mpu_l2_irq, mpu_l1_irq, dsp_l1_irq, dsp_l2_irq};
   assign unused_dsp0 = dsp_dma_req[0];

   obs_cfg_regs #(
      .ADDR_W(ADDR_W), .COMPAT_OFS(COMPAT_OFS), .MUX_OFS(MUX_OFS)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata), .sel_q(sel_q), .unlocked(unlocked)
   );

   obs_src_sel #(.SEL_W(DSEL_W), .N_SRC(N_DMA)) i_dma_sel (
      .clk(clk), .rst_n(rst_n), .enable(unlocked), .sel(sel_q.dsel),
      .src(dma_flat), .obs_bit(dma_bit), .obs_act(dma_act)
   );

   obs_src_sel #(.SEL_W(ISEL_W), .N_SRC(N_IRQ)) i_irq_sel (
      .clk(clk), .rst_n(rst_n), .enable(unlocked), .sel(sel_q.isel),
      .src(irq_flat), .obs_bit(irq_bit), .obs_act(irq_act)
   );

   obs_pad_drv i_rx_pad (
      .clk(clk), .rst_n(rst_n), .obs_act(dma_act), .obs_bit(dma_bit),
      .func_out(rx_func_out), .func_oe(rx_func_oe),
      .pin_out(rx_pin_out), .pin_oe(rx_pin_oe)
   );

   obs_pad_drv i_tx_pad (
      .clk(clk), .rst_n(rst_n), .obs_act(irq_act), .obs_bit(irq_bit),
      .func_out(tx_func_out), .func_oe(tx_func_oe),
      .pin_out(tx_pin_out), .pin_oe(tx_pin_oe)
   );

   AST_LOCKED_FUNCTIONAL: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |-> (rx_pin_out == rx_func_out && rx_pin_oe == rx_func_oe &&
                     tx_pin_out == tx_func_out && tx_pin_oe == tx_func_oe)); // R3
endmodule

// File: tb/test_dbg_obs_pinmux.sv
module test_dbg_obs_pinmux;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [19:0] dsp_dma_req = '0;
   logic [30:0] sys_dma_req = '0;
   logic [15:0] dsp_l2_irq = '0;
   logic [20:0] dsp_l1_irq = '0;
   logic [31:0] mpu_l1_irq = '0;
   logic [31:0] mpu_l2_irq = '0;
   logic rx_func_out = 1'b0, rx_func_oe = 1'b0, tx_func_out = 1'b0, tx_func_oe = 1'b0;
   logic rx_pin_out, rx_pin_oe, tx_pin_out, tx_pin_oe;

   int n_tests = 0;
   int n_fail = 0;
   bit done = 1'b0;
   bit m_unlock = 1'b0;
   int m_dsel = 0;
   int m_isel = 0;

   localparam logic [7:0]  A_COMPAT = 8'h00;
   localparam logic [7:0]  A_MUX    = 8'h10;
   localparam logic [31:0] KEY      = 32'h0000_EAEF;

   always #4 clk = ~clk;

   dbg_obs_pinmux i_dbg_obs_pinmux (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .dsp_dma_req(dsp_dma_req), .sys_dma_req(sys_dma_req),
      .dsp_l2_irq(dsp_l2_irq), .dsp_l1_irq(dsp_l1_irq),
      .mpu_l1_irq(mpu_l1_irq), .mpu_l2_irq(mpu_l2_irq),
      .rx_func_out(rx_func_out), .rx_func_oe(rx_func_oe),
      .tx_func_out(tx_func_out), .tx_func_oe(tx_func_oe),
      .rx_pin_out(rx_pin_out), .rx_pin_oe(rx_pin_oe),
      .tx_pin_out(tx_pin_out), .tx_pin_oe(tx_pin_oe)
   );

   function automatic logic [1:0] exp_rx(int s, bit unl);
      if (!unl || s == 0 || s > 50) return {rx_func_oe, rx_func_out};
      if (s <= 19) return {1'b1, dsp_dma_req[s]};
      return {1'b1, sys_dma_req[s-20]};
   endfunction

   function automatic logic [1:0] exp_tx(int s, bit unl);
      if (!unl || s == 0 || s > 101) return {tx_func_oe, tx_func_out};
      if (s <= 16) return {1'b1, dsp_l2_irq[s-1]};
      if (s <= 37) return {1'b1, dsp_l1_irq[s-17]};
      if (s <= 69) return {1'b1, mpu_l1_irq[s-38]};
      return {1'b1, mpu_l2_irq[s-70]};
   endfunction

   function automatic string rx_req(int s, bit unl);
      if (!unl) return "R3";
      if (s == 0) return "R10";
      if (s <= 19) return "R5";
      if (s <= 50) return "R6";
      return "R9";
   endfunction

   function automatic string tx_req(int s, bit unl);
      if (!unl) return "R3";
      if (s == 0) return "R10";
      if (s <= 37) return "R7";
      if (s <= 101) return "R8";
      return "R9";
   endfunction

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == A_COMPAT) m_unlock = (d == KEY);
      else if (a == A_MUX && m_unlock) begin
         m_dsel = int'(d[18:13]);
         m_isel = int'(d[12:6]);
      end
   endtask

   task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
      reg_addr = a;
      #1;
      check(req, "read", reg_rdata, exp);
   endtask

   task automatic pins_check(string tag);
      #1;
      check(rx_req(m_dsel, m_unlock), {tag, " rx"}, {30'd0, rx_pin_oe, rx_pin_out},
            {30'd0, exp_rx(m_dsel, m_unlock)});
      check(tx_req(m_isel, m_unlock), {tag, " tx"}, {30'd0, tx_pin_oe, tx_pin_out},
            {30'd0, exp_tx(m_isel, m_unlock)});
   endtask

   task automatic rand_src();
      dsp_dma_req = 20'($urandom); sys_dma_req = 31'($urandom);
      dsp_l2_irq  = 16'($urandom); dsp_l1_irq  = 21'($urandom);
      mpu_l1_irq  = $urandom;      mpu_l2_irq  = $urandom;
      {rx_func_out, rx_func_oe, tx_func_out, tx_func_oe} = 4'($urandom);
   endtask

   task automatic set_sel(int ds, int is);
      wr(A_MUX, {13'd0, 6'(ds), 7'(is), 6'd0});
   endtask

   // one-hot then inverted pattern on the selected lines
   task automatic hot_check(string tag);
      for (int p = 0; p < 2; p++) begin
         dsp_dma_req = '0; sys_dma_req = '0; dsp_l2_irq = '0;
         dsp_l1_irq = '0; mpu_l1_irq = '0; mpu_l2_irq = '0;
         if (m_dsel >= 1 && m_dsel <= 19) dsp_dma_req[m_dsel] = 1'b1;
         else if (m_dsel >= 20 && m_dsel <= 50) sys_dma_req[m_dsel-20] = 1'b1;
         if (m_isel >= 1 && m_isel <= 16) dsp_l2_irq[m_isel-1] = 1'b1;
         else if (m_isel >= 17 && m_isel <= 37) dsp_l1_irq[m_isel-17] = 1'b1;
         else if (m_isel >= 38 && m_isel <= 69) mpu_l1_irq[m_isel-38] = 1'b1;
         else if (m_isel >= 70 && m_isel <= 101) mpu_l2_irq[m_isel-70] = 1'b1;
         if (p == 1) begin
            dsp_dma_req = ~dsp_dma_req; sys_dma_req = ~sys_dma_req; dsp_l2_irq = ~dsp_l2_irq;
            dsp_l1_irq = ~dsp_l1_irq; mpu_l1_irq = ~mpu_l1_irq; mpu_l2_irq = ~mpu_l2_irq;
         end
         {rx_func_out, rx_func_oe, tx_func_out, tx_func_oe} = 4'b1010;
         pins_check(tag);
      end
   endtask

   initial begin : watchdog
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
         $finish;
      end
   end

   initial begin : main
      int dpts[6];
      int ipts[9];
      dpts = '{1, 19, 20, 50, 51, 0};
      ipts = '{1, 16, 17, 37, 38, 69, 70, 101, 102};
      void'($urandom(32'h0BD5_71A3));
      rand_src();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_check("R1", A_MUX, 32'h0);
      rd_check("R1", A_COMPAT, 32'h0);
      pins_check("R1 reset");

      // R3 locked write dropped
      wr(A_MUX, {13'd0, 6'd5, 7'd5, 6'd0});
      rd_check("R3", A_MUX, 32'h0);
      pins_check("R3 locked");

      // R2 unlock
      wr(A_COMPAT, KEY);
      rd_check("R2", A_COMPAT, KEY);

      // R4 reserved bits, R9 illegal selectors
      wr(A_MUX, 32'hFFFF_FFFF);
      rd_check("R4", A_MUX, 32'h0007_FFC0);
      rd_check("R4", 8'h08, 32'h0);
      pins_check("R9 max");

      // R5..R9 range edges
      for (int k = 0; k < 9; k++) begin
         set_sel(dpts[k % 6], ipts[k]);
         rd_check("R4", A_MUX, {13'd0, 6'(dpts[k % 6]), 7'(ipts[k]), 6'd0});
         hot_check("edge");
      end

      // R11 relock keeps selectors
      set_sel(33, 55);
      rand_src();
      pins_check("R11 pre");
      wr(A_COMPAT, 32'h0000_1234);
      rd_check("R2", A_COMPAT, 32'h0);
      rd_check("R11", A_MUX, {13'd0, 6'd33, 7'd55, 6'd0});
      pins_check("R11 locked");
      wr(A_COMPAT, KEY);
      hot_check("R11 resumed");

      // random mix
      for (int n = 0; n < 400; n++) begin
         int ds, is;
         ds = ($urandom % 8 == 0) ? int'($urandom % 64) : int'($urandom % 51);
         is = ($urandom % 8 == 0) ? int'($urandom % 128) : int'($urandom % 102);
         if ($urandom % 40 == 0) wr(A_COMPAT, ($urandom % 2 == 0) ? KEY : $urandom);
         set_sel(ds, is);
         rand_src();
         pins_check("rand");
         rand_src();
         pins_check("rand2");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule